// File: doc/BRIEF.md
# Receiver Gain Settling Controller

This block brings a receiver's variable-gain amplifier to a usable gain after the receive path is switched on. Once enabled, it waits a selectable number of ADC-rate strobes for the analog front end to settle. It then waits a selectable number of channel-filter-rate strobes, so that the filter output is valid. Next it averages a power-of-two number of magnitude samples into a signal-strength value.

That value is compared against a window built from a carrier-sense threshold and two margins. A value above the window lowers the gain by one step. A value below the window raises it by one step. Each gain step returns the controller to the second wait only. A value inside the window, or a gain already at its limit, ends the search. In automatic mode, a signal-strength value above the threshold raises a carrier-sense flag that stays set until the receiver is disabled.

The filter-rate strobe runs at twice the channel bandwidth. A wider channel filter therefore shortens settling, and a longer average lengthens it. A saturating counter reports how many gain changes the last search needed.

Top module: `agc_settle_ctrl`

## Requirements
- R1: While `rx_en` is low, `gain` equals `gain_max`, and `settled`, `carrier` and `gain_steps` are zero.
- R2: After enable, the block counts ADC strobes only. The codes 0, 1, 2 and 3 of `wait1_sel` select 16, 32, 64 and 128 strobes. With `adc_stb` held low, the block never settles.
- R3: The second wait counts filter strobes only. The codes 0, 1, 2 and 3 of `wait2_sel` select 16, 24, 32 and 48 strobes.
- R4: `rssi` is the sum of the next 2, 4, 8 or 16 filter-strobe samples of `mag` (for `avg_sel` codes 0 to 3), shifted right by 1 to 4 bits.
- R5: If `rssi > cs_thr + up_mrg + dn_mrg` (computed without overflow) and `gain` is above 0, then `gain` drops by one and the block re-enters the second wait.
- R6: If `rssi < cs_thr + up_mrg` and `gain` is below `gain_max`, then `gain` rises by one and the block re-enters the second wait.
- R7: Otherwise `settled` rises, and `gain` is then held whatever `mag` does.
- R8: At each decision, `carrier` is set if `cs_manual` is 0 and `rssi > cs_thr`. It stays set until `rx_en` falls. It is never set while `cs_manual` is 1.
- R9: Dropping `rx_en` clears `settled`, `carrier` and `gain_steps` on the next edge and reloads `gain`. Re-enabling restarts from the first wait.
- R10: `gain_steps` counts gain changes since enable and saturates at 15.
- R11: With both strobes present every cycle, `settled` rises exactly 1 + W1 + P·(W2 + A + 1) clock edges after `rx_en` is first sampled high. Here W1, W2 and A are the selected lengths, and P is the number of gain changes plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive chain enabled |
| adc_stb | input | 1 | ADC-rate clock enable |
| flt_stb | input | 1 | Filter-rate clock enable |
| mag | input | 8 | Signal magnitude sample |
| wait1_sel | input | 2 | First wait length code |
| wait2_sel | input | 2 | Second wait length code |
| avg_sel | input | 2 | Averaging length code |
| cs_thr | input | 8 | Carrier-sense threshold |
| up_mrg | input | 8 | Lower window margin above threshold |
| dn_mrg | input | 8 | Window width above the lower edge |
| cs_manual | input | 1 | 1 disables automatic carrier sense |
| gain_max | input | 5 | Highest gain code and start gain |
| gain | output | 5 | Current gain code |
| rssi | output | 8 | Last averaged magnitude |
| carrier | output | 1 | Carrier-sense flag |
| settled | output | 1 | Gain search finished |
| gain_steps | output | 4 | Gain changes since enable |

## Verification
The carrier-sense decision and a gain step share the same decision cycle. Carrier sense is judged on the pre-step average, while the step changes the input for all later averages. A fading-signal run provokes this: a strong first average both sets the flag and lowers the gain, and the weaker later averages raise the gain again. The bench expects the flag to stay set even though the final average is below the threshold. A second coincidence comes from dropping `rx_en` in the middle of a search. The same edge must abandon any pending step, and the bench checks the cleared outputs and the full restart time.

// File: rtl/agc_settle_ctrl.sv
module agc_settle_ctrl #(
  parameter int GAIN_W = 5,
  parameter int MAG_W  = 8,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              adc_stb,
  input  logic              flt_stb,
  input  logic [MAG_W-1:0]  mag,
  input  logic [1:0]        wait1_sel,
  input  logic [1:0]        wait2_sel,
  input  logic [1:0]        avg_sel,
  input  logic [MAG_W-1:0]  cs_thr,
  input  logic [MAG_W-1:0]  up_mrg,
  input  logic [MAG_W-1:0]  dn_mrg,
  input  logic              cs_manual,
  input  logic [GAIN_W-1:0] gain_max,
  output logic [GAIN_W-1:0] gain,
  output logic [MAG_W-1:0]  rssi,
  output logic              carrier,
  output logic              settled,
  output logic [STEP_W-1:0] gain_steps
);
  localparam int ACC_W = MAG_W + 4;
  localparam int CMP_W = MAG_W + 2;
  localparam int CNT_W = 8;

  typedef enum logic [2:0] {S_IDLE, S_W1, S_W2, S_AVG, S_DEC, S_SET} st_t;
  st_t st;

  logic [CNT_W-1:0] cnt, w1_len, w2_len, avg_len, cur_len;
  logic [ACC_W-1:0] acc, sum_nxt, avg_q;
  logic [CMP_W-1:0] lim_lo, lim_hi;
  logic             too_hi, too_lo, can_dn, can_up, cnt_last;

  assign w1_len  = 8'd16 << wait1_sel;
  assign w2_len  = (wait2_sel == 2'd3) ? 8'd48 : 8'd16 + {3'd0, wait2_sel, 3'd0};
  assign avg_len = 8'd2 << avg_sel;
  assign cur_len = (st == S_W1) ? w1_len : (st == S_W2) ? w2_len : avg_len;
  assign cnt_last = (cnt == cur_len - 8'd1);

  assign sum_nxt = acc + {{(ACC_W-MAG_W){1'b0}}, mag};
  assign avg_q   = sum_nxt >> ({1'b0, avg_sel} + 3'd1);

  assign lim_lo = {2'b0, cs_thr} + {2'b0, up_mrg};
  assign lim_hi = lim_lo + {2'b0, dn_mrg};
  assign too_hi = {2'b0, rssi} > lim_hi;
  assign too_lo = {2'b0, rssi} < lim_lo;
  assign can_dn = gain != '0;
  assign can_up = gain < gain_max;
  assign settled = (st == S_SET);

  logic [STEP_W-1:0] steps_inc;
  assign steps_inc = (&gain_steps) ? gain_steps : gain_steps + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      acc <= '0;
      gain <= '0;
      rssi <= '0;
      carrier <= 1'b0;
      gain_steps <= '0;
    end else if (!rx_en) begin
      st <= S_IDLE;
      cnt <= '0;
      acc <= '0;
      gain <= gain_max;
      carrier <= 1'b0;
      gain_steps <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          st  <= S_W1;
          cnt <= '0;
        end
        S_W1: if (adc_stb) begin
          if (cnt_last) begin
            st <= S_W2;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_W2: if (flt_stb) begin
          if (cnt_last) begin
            st <= S_AVG;
            cnt <= '0;
            acc <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_AVG: if (flt_stb) begin
          if (cnt_last) begin
            rssi <= avg_q[MAG_W-1:0];
            st <= S_DEC;
          end else begin
            acc <= sum_nxt;
            cnt <= cnt + 1'b1;
          end
        end
        S_DEC: begin
          if (!cs_manual && rssi > cs_thr) carrier <= 1'b1;
          cnt <= '0;
          if (too_hi && can_dn) begin
            gain <= gain - 1'b1;
            gain_steps <= steps_inc;
            st <= S_W2;
          end else if (too_lo && can_up) begin
            gain <= gain + 1'b1;
            gain_steps <= steps_inc;
            st <= S_W2;
          end else st <= S_SET;
        end
        default: ;
      endcase
    end
  end

  // R2
  w1_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_W1 && rx_en && !adc_stb) |=> (st == S_W1));

  // R5
  gain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && rx_en) |=> ({1'b0, gain} == {1'b0, $past(gain)} ||
      {1'b0, gain} == {1'b0, $past(gain)} + 1'b1 ||
      {1'b0, gain} + 1'b1 == {1'b0, $past(gain)}));

  // R7
  hold_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && rx_en) |=> (settled && $stable(gain)));

  // R8
  cs_manual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier) |-> !$past(cs_manual));

  // R9
  drop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!settled && !carrier && gain_steps == '0));

  // R10
  steps_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en |=> (gain_steps >= $past(gain_steps)));
endmodule

// File: tb/agc_settle_ctrl_tb_top.sv
module agc_settle_ctrl_tb_top;
  logic clk = 0, rst_n = 0, rx_en = 0, adc_stb = 1, flt_stb = 1, cs_manual = 0;
  logic [7:0] mag, cs_thr = 0, up_mrg = 0, dn_mrg = 0;
  logic [1:0] wait1_sel = 0, wait2_sel = 0, avg_sel = 0;
  logic [4:0] gain_max = 31, gain;
  logic [7:0] rssi;
  logic carrier, settled;
  logic [3:0] gain_steps;

  int n_chk = 0, n_ok = 0, cyc = 0, mmode = 0;
  bit slow = 0, adc_block = 0, ph = 0, faded = 0;

  always #10 clk = ~clk;

  agc_settle_ctrl dut_i (.clk(clk), .rst_n(rst_n), .rx_en(rx_en), .adc_stb(adc_stb),
    .flt_stb(flt_stb), .mag(mag), .wait1_sel(wait1_sel), .wait2_sel(wait2_sel),
    .avg_sel(avg_sel), .cs_thr(cs_thr), .up_mrg(up_mrg), .dn_mrg(dn_mrg),
    .cs_manual(cs_manual), .gain_max(gain_max), .gain(gain), .rssi(rssi),
    .carrier(carrier), .settled(settled), .gain_steps(gain_steps));

  always_comb begin
    if (mmode == 0) mag = 8'(8 * int'(gain) + (ph ? 6 : 0));
    else if (mmode == 1) mag = faded ? 8'(4 * int'(gain) + 3) : 8'd230;
    else mag = 8'd255;
  end

  always @(posedge clk) begin
    if (flt_stb) ph <= ~ph;
    if (!rx_en) faded <= 0;
    else if (gain != gain_max) faded <= 1;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    adc_stb <= adc_block ? 1'b0 : (slow ? (cyc % 2 == 0) : 1'b1);
    flt_stb <= slow ? (cyc % 3 == 0) : 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (ok) n_ok++;
    else $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
  endtask

  initial begin
    #3800000;
    n_chk++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", n_ok, n_chk);
    $finish;
  end

  task automatic model(input int gm, input int th, input int up, input int dn, input bit man,
                       output int eg, output int est, output int ers, output int ecs, output int raw);
    int g = gm;
    raw = 0; ecs = 0; ers = 0;
    for (int k = 0; k < 64; k++) begin
      int r = 8 * g + 3;
      ers = r;
      if (!man && r > th) ecs = 1;
      if (r > th + up + dn && g > 0) begin g--; raw++; end
      else if (r < th + up && g < gm) begin g++; raw++; end
      else break;
    end
    eg = g;
    est = raw > 15 ? 15 : raw;
  endtask

  task automatic run(output int n);
    n = 0;
    @(negedge clk);
    rx_en = 1;
    while (n < 30000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (settled) break;
    end
  endtask

  task automatic stop_rx();
    rx_en = 0;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    int n, eg, est, ers, ecs, raw, lens1[4], lens2[4];
    lens1 = '{16, 32, 64, 128};
    lens2 = '{16, 24, 32, 48};
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(gain == 31 && !settled && !carrier && gain_steps == 0, "R1 idle state", gain, 31);

    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++) begin
          int sc = (a * 16 + b * 4 + c) % 3;
          wait1_sel = 2'(a); wait2_sel = 2'(b); avg_sel = 2'(c);
          case (sc)
            0: begin cs_thr = 100; up_mrg = 10; dn_mrg = 20; gain_max = 31; cs_manual = 0; end
            1: begin cs_thr = 200; up_mrg = 20; dn_mrg = 10; gain_max = 20; cs_manual = 0; end
            default: begin cs_thr = 60; up_mrg = 4; dn_mrg = 200; gain_max = 31; cs_manual = 1; end
          endcase
          mmode = 0;
          model(gain_max, cs_thr, up_mrg, dn_mrg, cs_manual, eg, est, ers, ecs, raw);
          run(n);
          chk(gain == 5'(eg), "R5 R7 final gain", gain, eg);
          chk(gain_steps == 4'(est), "R10 step count", gain_steps, est);
          chk(rssi == 8'(ers), "R4 average", rssi, ers);
          chk(carrier == ecs, "R8 carrier", carrier, ecs);
          chk(n == 1 + lens1[a] + (raw + 1) * (lens2[b] + (2 << c) + 1),
              "R11 R2 R3 settle time", n, 1 + lens1[a] + (raw + 1) * (lens2[b] + (2 << c) + 1));
          stop_rx();
          chk(!settled && !carrier && gain_steps == 0 && gain == gain_max, "R9 R1 drop", gain, gain_max);
        end

    // R6: strong then faded signal, one step down then one up, carrier sticky
    wait1_sel = 0; wait2_sel = 0; avg_sel = 1;
    cs_thr = 150; up_mrg = 10; dn_mrg = 60; gain_max = 31; cs_manual = 0; mmode = 1;
    run(n);
    chk(gain == 31 && gain_steps == 2, "R6 raise after fade", gain_steps, 2);
    chk(rssi == 127 && carrier, "R8 sticky carrier", rssi, 127);
    chk(n == 1 + 16 + 3 * (16 + 4 + 1), "R11 fade timing", n, 1 + 16 + 3 * 21);

    // R7: gain held once settled under a changed input
    mmode = 2;
    repeat (50) @(negedge clk);
    chk(gain == 31 && settled, "R7 hold", gain, 31);
    stop_rx();

    // R5: minimum gain limit
    mmode = 0; gain_max = 3; cs_thr = 0; up_mrg = 0; dn_mrg = 0;
    run(n);
    chk(gain == 0 && gain_steps == 3 && settled, "R5 min limit", gain, 0);
    chk(rssi == 3, "R4 min rssi", rssi, 3);
    stop_rx();

    // R9: drop mid-search, then restart from first wait
    gain_max = 31; cs_thr = 100; up_mrg = 10; dn_mrg = 20; wait1_sel = 1;
    rx_en = 1;
    repeat (120) @(negedge clk);
    stop_rx();
    chk(!settled && !carrier && gain_steps == 0 && gain == 31, "R9 mid drop", gain, 31);
    run(n);
    chk(n == 1 + 32 + 17 * 21, "R9 restart time", n, 1 + 32 + 17 * 21);
    stop_rx();

    // R2: no ADC strobes, never settles
    adc_block = 1;
    rx_en = 1;
    repeat (300) @(negedge clk);
    chk(!settled && gain == 31, "R2 adc gating", settled, 0);
    stop_rx();
    adc_block = 0;

    // R3: slow strobes give same result, longer time
    slow = 1; wait1_sel = 1; wait2_sel = 2; avg_sel = 3;
    model(31, 100, 10, 20, 0, eg, est, ers, ecs, raw);
    run(n);
    chk(gain == 5'(eg) && rssi == 8'(ers), "R3 slow result", gain, eg);
    chk(n > 1 + 32 + (raw + 1) * (32 + 16 + 1), "R3 slow time", n, 1 + 32 + (raw + 1) * 49);
    stop_rx();

    $display("%0d/%0d checks passed", n_ok, n_chk);
    $finish;
  end
endmodule